// File: doc/BRIEF.md
# Two-Wire Bus Controller Host Register File

This block is the host-facing register file and status logic of a two-wire serial bus controller. A host reaches it through a byte-wide I/O port with a 3-bit offset. It holds the bytes moving between the host and the bus and the status flags. It also holds the control settings that steer a separate byte-level bus engine. The engine reports events to this block: a byte was received, a bus error occurred, a NACK came back, the bus stalled after START, mastership is held, or the bus is busy. In return the block drives the START and STOP requests, the acknowledge policy, the enable and the clock period setting to the engine.

Event flags are sticky and the host clears them by writing a 1 to the flag's bit. START and STOP are requests that stay pending until the engine accepts them, and they then clear in hardware. While the controller is disabled, the first control register is locked. It reads as zero, ignores writes and is emptied, so a stale request can never reach the engine.

Top module: `twc_regfile`

## Requirements
- R1: Offset 0 is the data register. A read returns the byte captured on the most recent received-byte event. A host read or write of offset 0 clears data-ready, and a received-byte event in the same cycle wins over the clear. A write loads the transmit byte output `tx_data`.
- R2: The status register at offset 1 reads data-ready at bit 6, bus error at bit 5, NACK at bit 4 and stall-after-start at bit 3. Bit 1 is the live master input. Bits 7, 2 and 0 read 0.
- R3: The bus error, NACK and stall flags are set by their engine event and stay set. Writing 1 to a flag's bit at offset 1 clears it. Writing 0 leaves it unchanged. An event in the same cycle as a clear keeps the flag set.
- R4: The control-status register at offset 2 reads bus-busy at bit 1 and 0 elsewhere. Bus-busy is set while the engine's busy input is high and is cleared by writing 1 to bit 1.
- R5: Control 2 at offset 5 is a full read/write byte. Bit 0 drives `ctl_enable` and bits 7:1 drive `scl_period`. Writing 0x70 reads back 0x70, with the enable at 0 and a period of 0x38.
- R6: While enable is 0, control 1 at offset 3 reads 0x00 and writes to it have no effect. Clearing enable empties every control 1 bit, including pending requests.
- R7: While enabled, control 1 stores stall-after-start enable at bit 7, interrupt enable at bit 6 and ack control at bit 4, and these read back. Ack control set drives `nack_next` high, which tells the engine to NACK the next received byte.
- R8: Writing 1 to control 1 bit 0 (START) or bit 1 (STOP) raises `start_req` or `stop_req`. The request stays high until the matching accept pulse and drops in the cycle after it. A new write of 1 in the same cycle as the accept keeps the request. Both bits read back as their pending state.
- R9: The own-address register at offset 4 is a full 8-bit read/write register that drives `own_addr`.
- R10: Offsets 6 and 7 read 0x00, and writes to them change no register or output.
- R11: After reset every register reads 0x00 except the live master bit, and every request, enable and data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | AW (3) | Register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected offset |
| eng_byte_done | input | 1 | Engine received a byte |
| eng_rx_data | input | 8 | Received byte, valid with eng_byte_done |
| eng_bus_err | input | 1 | Bus error event |
| eng_nack | input | 1 | NACK received event |
| eng_stall | input | 1 | Stall after START event |
| eng_master | input | 1 | Engine currently holds mastership |
| eng_bus_busy | input | 1 | Bus is busy |
| eng_start_ack | input | 1 | Engine accepted the START request |
| eng_stop_ack | input | 1 | Engine accepted the STOP request |
| start_req | output | 1 | START request pending |
| stop_req | output | 1 | STOP request pending |
| nack_next | output | 1 | NACK the next received byte |
| ctl_enable | output | 1 | Controller enable |
| scl_period | output | 7 | Clock period setting |
| own_addr | output | 8 | Own address register |
| tx_data | output | 8 | Byte to transmit |

## Verification
The bench goes after the races: a flag clear that coincides with its set event, a data-register access that coincides with a received byte, and a request write that coincides with the engine's accept. A design that let the clear win in these cases would drop an event, lose a byte's arrival, or lose a START. It also writes control 1 while disabled and then disables with requests pending. A design that failed here would leak an interrupt enable or a stale START to the engine. Writes of 0 to flags and writes to the two unused offsets are followed by a full readback, which exposes any register that a stray decode disturbed.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int BW = 8;
  typedef logic [BW-1:0] byte_t;

  localparam int OFF_DATA  = 0;
  localparam int OFF_STAT  = 1;
  localparam int OFF_CSTAT = 2;
  localparam int OFF_CTL1  = 3;
  localparam int OFF_OWN   = 4;
  localparam int OFF_CTL2  = 5;

  localparam int ST_DRDY  = 6;
  localparam int ST_BERR  = 5;
  localparam int ST_NACK  = 4;
  localparam int ST_STALL = 3;
  localparam int ST_MSTR  = 1;
  localparam int CS_BUSY  = 1;

  localparam int C1_STALLEN = 7;
  localparam int C1_IRQEN   = 6;
  localparam int C1_ACK     = 4;
  localparam int C1_STOP    = 1;
  localparam int C1_START   = 0;
  localparam int C2_EN      = 0;

  // sticky flag: an event beats a clear in the same cycle
  function automatic logic sticky_next(logic cur, logic set_ev, logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

  // self-clearing request, flushed while disabled
  function automatic logic req_next(logic cur, logic req, logic taken, logic en);
    return en & (req | (cur & ~taken));
  endfunction
endpackage

// File: rtl/twc_status_regs.sv
module twc_status_regs
  import twc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_data,
  input  logic  rd_data,
  input  byte_t wdata,
  input  logic  clr_berr,
  input  logic  clr_nack,
  input  logic  clr_stall,
  input  logic  clr_busy,
  input  logic  eng_byte_done,
  input  byte_t eng_rx_data,
  input  logic  eng_bus_err,
  input  logic  eng_nack,
  input  logic  eng_stall,
  input  logic  eng_master,
  input  logic  eng_bus_busy,
  output byte_t stat_o,
  output byte_t cstat_o,
  output byte_t rx_o,
  output byte_t tx_o
);
  logic  drdy_q, berr_q, nack_q, stall_q, busy_q;
  byte_t rx_q, tx_q;
  logic  data_touch;

  assign data_touch = wr_data | rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q  <= 1'b0;
      berr_q  <= 1'b0;
      nack_q  <= 1'b0;
      stall_q <= 1'b0;
      busy_q  <= 1'b0;
      rx_q    <= '0;
      tx_q    <= '0;
    end else begin
      drdy_q  <= sticky_next(drdy_q,  eng_byte_done, data_touch);
      berr_q  <= sticky_next(berr_q,  eng_bus_err,   clr_berr);
      nack_q  <= sticky_next(nack_q,  eng_nack,      clr_nack);
      stall_q <= sticky_next(stall_q, eng_stall,     clr_stall);
      busy_q  <= sticky_next(busy_q,  eng_bus_busy,  clr_busy);
      if (eng_byte_done) rx_q <= eng_rx_data;
      if (wr_data)       tx_q <= wdata;
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[ST_DRDY]  = drdy_q;
    stat_o[ST_BERR]  = berr_q;
    stat_o[ST_NACK]  = nack_q;
    stat_o[ST_STALL] = stall_q;
    stat_o[ST_MSTR]  = eng_master;
    cstat_o          = '0;
    cstat_o[CS_BUSY] = busy_q;
  end

  assign rx_o = rx_q;
  assign tx_o = tx_q;

  p_drdy_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_byte_done |=> drdy_q);
  p_drdy_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_touch && !eng_byte_done) |=> !drdy_q);
  p_berr_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_berr && !eng_bus_err) |=> !berr_q);
  p_berr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_q && !clr_berr) |=> berr_q);
  p_busy_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && !eng_bus_busy) |=> !busy_q);
endmodule

// File: rtl/twc_ctrl_regs.sv
module twc_ctrl_regs
  import twc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl1,
  input  logic       wr_own,
  input  logic       wr_ctl2,
  input  byte_t      wdata,
  input  logic       eng_start_ack,
  input  logic       eng_stop_ack,
  output byte_t      ctl1_o,
  output byte_t      own_o,
  output byte_t      ctl2_o,
  output logic       start_req,
  output logic       stop_req,
  output logic       nack_next,
  output logic       enable,
  output logic [6:0] scl_period
);
  byte_t ctl2_q, own_q;
  logic  sen_q, ien_q, ack_q, start_q, stop_q;
  logic  en_q;

  assign en_q = ctl2_q[C2_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl2_q <= '0;
      own_q  <= '0;
    end else begin
      if (wr_ctl2) ctl2_q <= wdata;
      if (wr_own)  own_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sen_q <= 1'b0;
      ien_q <= 1'b0;
      ack_q <= 1'b0;
    end else if (!en_q) begin
      sen_q <= 1'b0;
      ien_q <= 1'b0;
      ack_q <= 1'b0;
    end else if (wr_ctl1) begin
      sen_q <= wdata[C1_STALLEN];
      ien_q <= wdata[C1_IRQEN];
      ack_q <= wdata[C1_ACK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= req_next(start_q, wr_ctl1 & wdata[C1_START], eng_start_ack, en_q);
      stop_q  <= req_next(stop_q,  wr_ctl1 & wdata[C1_STOP],  eng_stop_ack,  en_q);
    end
  end

  always_comb begin
    ctl1_o = '0;
    if (en_q) begin
      ctl1_o[C1_STALLEN] = sen_q;
      ctl1_o[C1_IRQEN]   = ien_q;
      ctl1_o[C1_ACK]     = ack_q;
      ctl1_o[C1_STOP]    = stop_q;
      ctl1_o[C1_START]   = start_q;
    end
  end

  assign own_o      = own_q;
  assign ctl2_o     = ctl2_q;
  assign enable     = en_q;
  assign scl_period = ctl2_q[7:1];
  assign start_req  = start_q & en_q;
  assign stop_req   = stop_q & en_q;
  assign nack_next  = ack_q & en_q;

  p_ctl1_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && wr_ctl1) |=> !ien_q);
  p_start_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !eng_start_ack && !wr_ctl2) |=> start_req);
  p_start_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && eng_start_ack && !(wr_ctl1 && wdata[C1_START])) |=> !start_req);
  p_stop_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && eng_stop_ack && !(wr_ctl1 && wdata[C1_STOP])) |=> !stop_req);
endmodule

// File: rtl/twc_read_mux.sv
module twc_read_mux
  import twc_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic [AW-1:0] addr,
  input  byte_t         rx_i,
  input  byte_t         stat_i,
  input  byte_t         cstat_i,
  input  byte_t         ctl1_i,
  input  byte_t         own_i,
  input  byte_t         ctl2_i,
  output byte_t         rdata
);
  always_comb begin
    case (addr)
      AW'(OFF_DATA):  rdata = rx_i;
      AW'(OFF_STAT):  rdata = stat_i;
      AW'(OFF_CSTAT): rdata = cstat_i;
      AW'(OFF_CTL1):  rdata = ctl1_i;
      AW'(OFF_OWN):   rdata = own_i;
      AW'(OFF_CTL2):  rdata = ctl2_i;
      default:        rdata = '0;
    endcase
  end
endmodule

// File: rtl/twc_regfile.sv
module twc_regfile
  import twc_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          eng_byte_done,
  input  logic [7:0]    eng_rx_data,
  input  logic          eng_bus_err,
  input  logic          eng_nack,
  input  logic          eng_stall,
  input  logic          eng_master,
  input  logic          eng_bus_busy,
  input  logic          eng_start_ack,
  input  logic          eng_stop_ack,
  output logic          start_req,
  output logic          stop_req,
  output logic          nack_next,
  output logic          ctl_enable,
  output logic [6:0]    scl_period,
  output logic [7:0]    own_addr,
  output logic [7:0]    tx_data
);
  logic  wr_data, rd_data, wr_stat, wr_cstat, wr_ctl1, wr_own, wr_ctl2;
  byte_t stat_b, cstat_b, rx_b, ctl1_b, own_b, ctl2_b;

  assign wr_data  = host_wr && (host_addr == AW'(OFF_DATA));
  assign rd_data  = host_rd && (host_addr == AW'(OFF_DATA));
  assign wr_stat  = host_wr && (host_addr == AW'(OFF_STAT));
  assign wr_cstat = host_wr && (host_addr == AW'(OFF_CSTAT));
  assign wr_ctl1  = host_wr && (host_addr == AW'(OFF_CTL1));
  assign wr_own   = host_wr && (host_addr == AW'(OFF_OWN));
  assign wr_ctl2  = host_wr && (host_addr == AW'(OFF_CTL2));

  twc_status_regs u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .wdata         (host_wdata),
    .clr_berr      (wr_stat & host_wdata[ST_BERR]),
    .clr_nack      (wr_stat & host_wdata[ST_NACK]),
    .clr_stall     (wr_stat & host_wdata[ST_STALL]),
    .clr_busy      (wr_cstat & host_wdata[CS_BUSY]),
    .eng_byte_done (eng_byte_done),
    .eng_rx_data   (eng_rx_data),
    .eng_bus_err   (eng_bus_err),
    .eng_nack      (eng_nack),
    .eng_stall     (eng_stall),
    .eng_master    (eng_master),
    .eng_bus_busy  (eng_bus_busy),
    .stat_o        (stat_b),
    .cstat_o       (cstat_b),
    .rx_o          (rx_b),
    .tx_o          (tx_data)
  );

  twc_ctrl_regs u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ctl1       (wr_ctl1),
    .wr_own        (wr_own),
    .wr_ctl2       (wr_ctl2),
    .wdata         (host_wdata),
    .eng_start_ack (eng_start_ack),
    .eng_stop_ack  (eng_stop_ack),
    .ctl1_o        (ctl1_b),
    .own_o         (own_b),
    .ctl2_o        (ctl2_b),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .nack_next     (nack_next),
    .enable        (ctl_enable),
    .scl_period    (scl_period)
  );

  twc_read_mux #(.AW(AW)) u_rmux (
    .addr    (host_addr),
    .rx_i    (rx_b),
    .stat_i  (stat_b),
    .cstat_i (cstat_b),
    .ctl1_i  (ctl1_b),
    .own_i   (own_b),
    .ctl2_i  (ctl2_b),
    .rdata   (host_rdata)
  );

  assign own_addr = own_b;

  p_hidden_offsets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr >= AW'(6)) |=> $stable(own_addr) && $stable(tx_data) && $stable(ctl_enable));
  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> (!start_req && !stop_req && !nack_next));
endmodule

// File: tb/twc_regfile_bench.sv
`timescale 1ns/1ps
module twc_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       eng_byte_done = 0, eng_bus_err = 0, eng_nack = 0, eng_stall = 0;
  logic       eng_master = 0, eng_bus_busy = 0, eng_start_ack = 0, eng_stop_ack = 0;
  logic [7:0] eng_rx_data = '0;
  logic       start_req, stop_req, nack_next, ctl_enable;
  logic [6:0] scl_period;
  logic [7:0] own_addr, tx_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  twc_regfile u_twc_regfile (.*);

  // behavioural reference state
  bit [7:0] m_ctl2, m_own, m_rx, m_tx;
  bit m_drdy, m_berr, m_nack, m_stall, m_busy, m_sen, m_ien, m_ack, m_start, m_stop;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl2 <= 0; m_own <= 0; m_rx <= 0; m_tx <= 0;
      m_drdy <= 0; m_berr <= 0; m_nack <= 0; m_stall <= 0; m_busy <= 0;
      m_sen <= 0; m_ien <= 0; m_ack <= 0; m_start <= 0; m_stop <= 0;
    end else begin
      if (eng_byte_done) m_rx <= eng_rx_data;
      if (eng_byte_done) m_drdy <= 1;
      else if (host_addr == 0 && (host_wr || host_rd)) m_drdy <= 0;
      if (eng_bus_err) m_berr <= 1; else if (host_wr && host_addr == 1 && host_wdata[5]) m_berr <= 0;
      if (eng_nack)    m_nack <= 1; else if (host_wr && host_addr == 1 && host_wdata[4]) m_nack <= 0;
      if (eng_stall)   m_stall <= 1; else if (host_wr && host_addr == 1 && host_wdata[3]) m_stall <= 0;
      if (eng_bus_busy) m_busy <= 1; else if (host_wr && host_addr == 2 && host_wdata[1]) m_busy <= 0;
      if (host_wr && host_addr == 0) m_tx <= host_wdata;
      if (host_wr && host_addr == 4) m_own <= host_wdata;
      if (host_wr && host_addr == 5) m_ctl2 <= host_wdata;
      if (m_ctl2[0] == 0) begin
        m_sen <= 0; m_ien <= 0; m_ack <= 0; m_start <= 0; m_stop <= 0;
      end else begin
        if (host_wr && host_addr == 3) begin
          m_sen <= host_wdata[7]; m_ien <= host_wdata[6]; m_ack <= host_wdata[4];
        end
        if (host_wr && host_addr == 3 && host_wdata[0]) m_start <= 1;
        else if (eng_start_ack) m_start <= 0;
        if (host_wr && host_addr == 3 && host_wdata[1]) m_stop <= 1;
        else if (eng_stop_ack) m_stop <= 0;
      end
    end
  end

  function automatic bit [7:0] m_read(input bit [2:0] a);
    case (a)
      0: return m_rx;
      1: return {1'b0, m_drdy, m_berr, m_nack, m_stall, 1'b0, eng_master, 1'b0};
      2: return {6'b0, m_busy, 1'b0};
      3: return m_ctl2[0] ? {m_sen, m_ien, 1'b0, m_ack, 2'b00, m_stop, m_start} : 8'h00;
      4: return m_own;
      5: return m_ctl2;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input bit [2:0] a);
    case (a)
      0: return "R1"; 1: return "R2"; 2: return "R4"; 3: return "R6";
      4: return "R9"; 5: return "R5"; default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the reference
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(host_rdata == m_read(host_addr), tag_of(host_addr), host_rdata, m_read(host_addr));
      chk(start_req == (m_ctl2[0] & m_start), "R8", start_req, m_ctl2[0] & m_start);
      chk(stop_req == (m_ctl2[0] & m_stop), "R8", stop_req, m_ctl2[0] & m_stop);
      chk(nack_next == (m_ctl2[0] & m_ack), "R7", nack_next, m_ctl2[0] & m_ack);
      chk(ctl_enable == m_ctl2[0], "R5", ctl_enable, m_ctl2[0]);
      chk(scl_period == m_ctl2[7:1], "R5", scl_period, m_ctl2[7:1]);
      chk(own_addr == m_own, "R9", own_addr, m_own);
      chk(tx_data == m_tx, "R1", tx_data, m_tx);
    end
  end

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input bit [2:0] a, output bit [7:0] v);
    @(negedge clk); host_addr = a; host_rd = 1; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic expect_rd(input bit [2:0] a, input bit [7:0] e, input string tag);
    bit [7:0] v;
    rd(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    for (int a = 0; a < 8; a++) expect_rd(3'(a), 8'h00, "R11");
    chk({start_req, stop_req, nack_next, ctl_enable} == 0, "R11", {start_req, stop_req, nack_next, ctl_enable}, 0);
    chk(tx_data == 0, "R11", tx_data, 0);

    // R5 control 2 readback
    wr(5, 8'h70);
    expect_rd(5, 8'h70, "R5");
    chk(scl_period == 7'h38, "R5", scl_period, 7'h38);
    chk(ctl_enable == 0, "R5", ctl_enable, 0);

    // R6 locked while disabled
    wr(3, 8'hFF);
    expect_rd(3, 8'h00, "R6");
    chk(start_req == 0, "R6", start_req, 0);

    // R7 enabled control 1
    wr(5, 8'h71);
    wr(3, 8'hD0);
    expect_rd(3, 8'hD0, "R7");
    chk(nack_next == 1, "R7", nack_next, 1);

    // R8 START pending then accepted
    wr(3, 8'h01);
    idle(3);
    chk(start_req == 1, "R8", start_req, 1);
    expect_rd(3, 8'h01, "R8");
    @(negedge clk); eng_start_ack = 1;
    @(negedge clk); eng_start_ack = 0;
    chk(start_req == 0, "R8", start_req, 0);
    // STOP written in the same cycle as an accept stays pending
    wr(3, 8'h02);
    @(negedge clk); host_addr = 3; host_wdata = 8'h02; host_wr = 1; eng_stop_ack = 1;
    @(negedge clk); host_wr = 0; eng_stop_ack = 0;
    chk(stop_req == 1, "R8", stop_req, 1);
    @(negedge clk); eng_stop_ack = 1;
    @(negedge clk); eng_stop_ack = 0;
    chk(stop_req == 0, "R8", stop_req, 0);

    // R1 / R2 received byte
    @(negedge clk); eng_rx_data = 8'hA5; eng_byte_done = 1;
    @(negedge clk); eng_byte_done = 0;
    expect_rd(1, 8'h40, "R2");
    expect_rd(0, 8'hA5, "R1");
    expect_rd(1, 8'h00, "R1");
    // byte arriving in the same cycle as a data read keeps data-ready
    @(negedge clk); host_addr = 0; host_rd = 1; eng_rx_data = 8'h5C; eng_byte_done = 1;
    @(negedge clk); host_rd = 0; eng_byte_done = 0;
    expect_rd(1, 8'h40, "R1");
    wr(0, 8'h3C);
    chk(tx_data == 8'h3C, "R1", tx_data, 8'h3C);
    expect_rd(1, 8'h00, "R1");

    // R3 sticky flags with write-one-to-clear
    @(negedge clk); eng_bus_err = 1; eng_nack = 1; eng_stall = 1; eng_master = 1;
    @(negedge clk); eng_bus_err = 0; eng_nack = 0; eng_stall = 0;
    expect_rd(1, 8'h3A, "R2");
    wr(1, 8'h00);
    expect_rd(1, 8'h3A, "R3");
    wr(1, 8'h20);
    expect_rd(1, 8'h1A, "R3");
    @(negedge clk); host_addr = 1; host_wdata = 8'h18; host_wr = 1; eng_nack = 1;
    @(negedge clk); host_wr = 0; eng_nack = 0;
    expect_rd(1, 8'h12, "R3");
    eng_master = 0;
    wr(1, 8'hFF);
    expect_rd(1, 8'h00, "R3");

    // R4 bus busy
    @(negedge clk); eng_bus_busy = 1;
    @(negedge clk); eng_bus_busy = 0;
    expect_rd(2, 8'h02, "R4");
    wr(2, 8'h01);
    expect_rd(2, 8'h02, "R4");
    wr(2, 8'h02);
    expect_rd(2, 8'h00, "R4");

    // R9 own address
    wr(4, 8'h5A);
    expect_rd(4, 8'h5A, "R9");

    // R10 unused offsets
    wr(6, 8'hFF);
    wr(7, 8'hFF);
    expect_rd(6, 8'h00, "R10");
    expect_rd(7, 8'h00, "R10");
    expect_rd(4, 8'h5A, "R10");
    expect_rd(5, 8'h71, "R10");
    expect_rd(0, 8'h5C, "R10");

    // R6 disabling flushes pending control bits
    wr(3, 8'hD3);
    wr(5, 8'h70);
    chk(start_req == 0, "R6", start_req, 0);
    wr(5, 8'h71);
    expect_rd(3, 8'h00, "R6");
    chk(stop_req == 0, "R6", stop_req, 0);

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule